// File: doc/BRIEF.md
# Port Control Register Block with Set/Clear Addressing

This block holds the control and status state of one storage port and exposes it on a simple 32-bit register bus. Each control word has two write addresses. A one written to the set address turns the matching bit on. A one written to the clear address turns it off. A zero has no effect at either address. Software can therefore change any single control without a read-modify-write.

The control word carries three controls: a port-reset hold, a 32-bit activation enable and a multiplier context-switch enable. The status word reports port-ready, which is high when the link reports ready and port reset is released. Three interrupt sources latch into a pending register: command complete, command error and any change of port-ready. The interrupt enable register also uses set/clear addressing. The interrupt output is high while any enabled source is pending.

Top module: `port_ctrl_regs`

## Requirements
- R1: After reset the control word reads 0x00000001 (port reset held), the enable and pending registers read 0, port-ready is 0 and `irq` is low.
- R2: A write to byte offset 0x1000 sets every implemented control bit that is one in the write data; bits written as zero keep their value.
- R3: A write to byte offset 0x1004 clears every implemented control bit that is one in the write data; bits written as zero keep their value. It also reads back the control word.
- R4: Only control bits 0 (port reset), 10 (32-bit activation) and 13 (multiplier enable) are implemented. All other control bits read 0. The three bits drive `portResetOut`, `act32Out` and `pmEnableOut`.
- R5: A read of offset 0x1000 returns port-ready in bit 31 and the control bits in their own positions. Port-ready is registered: it follows `linkReady` AND NOT port-reset one clock after either input changes.
- R6: Interrupt enable bits 0 (command complete), 1 (command error) and 2 (port-ready change) are set by writing ones to offset 0x1010 and cleared by writing ones to offset 0x1014. Both offsets read the enable word. Higher bits read 0.
- R7: Pending bit 0 is set by a `cmdDone` pulse and pending bit 1 by a `cmdErr` pulse. Pending bit 2 is set in the same cycle that port-ready changes, in either direction. Writing ones to offset 0x1008 clears the matching pending bits, and a new event in the same cycle wins over the clear. Offset 0x1008 reads the pending word.
- R8: `irq` is high exactly when some pending bit has its enable bit set.
- R9: A write to any other offset changes no register, and a read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | 13 | Byte offset for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| linkReady | input | 1 | Link layer reports a usable link |
| cmdDone | input | 1 | Command-complete event pulse |
| cmdErr | input | 1 | Command-error event pulse |
| portResetOut | output | 1 | Port reset control |
| act32Out | output | 1 | 32-bit activation control |
| pmEnableOut | output | 1 | Multiplier context-switch control |
| irq | output | 1 | Interrupt request |

## Verification
A wrong decode or a lost mask shows up on the next read. It appears as an unexpected bit at the set, clear or enable offsets, or as a changed word after a write to an unmapped offset. A fault in the ready path shows at bit 31 of the status read one clock after `linkReady` or port reset moves. It also shows in pending bit 2 in that same clock. A wrong priority between an event and a pending clear leaves `irq` low on the clock after the write, where it should stay high.

// File: rtl/portctl_pkg.sv
package portctl_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 13;

  localparam logic [ADDR_W-1:0] OFS_CTRL_SET = 13'h1000;
  localparam logic [ADDR_W-1:0] OFS_CTRL_CLR = 13'h1004;
  localparam logic [ADDR_W-1:0] OFS_PEND     = 13'h1008;
  localparam logic [ADDR_W-1:0] OFS_IE_SET   = 13'h1010;
  localparam logic [ADDR_W-1:0] OFS_IE_CLR   = 13'h1014;

  localparam int BIT_RESET = 0;
  localparam int BIT_ACT32 = 10;
  localparam int BIT_PMEN  = 13;
  localparam int BIT_READY = DATA_W - 1;

  localparam int EV_DONE  = 0;
  localparam int EV_ERR   = 1;
  localparam int EV_READY = 2;
  localparam int EV_N     = 3;

  localparam logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'(1) << BIT_RESET) | (DATA_W'(1) << BIT_ACT32) | (DATA_W'(1) << BIT_PMEN);
  localparam logic [DATA_W-1:0] CTRL_INIT = DATA_W'(1) << BIT_RESET;
  localparam logic [DATA_W-1:0] EV_MASK   = (DATA_W'(1) << EV_N) - DATA_W'(1);

  typedef enum logic [2:0] {
    RD_NONE, RD_STATUS, RD_CTRL, RD_PEND, RD_IE
  } rdSel_e;

  typedef struct packed {
    logic   ctrlSet;
    logic   ctrlClr;
    logic   ieSet;
    logic   ieClr;
    logic   pendClr;
    rdSel_e rdSel;
  } regStb_t;
endpackage

// File: rtl/port_ctrl_decode.sv
module port_ctrl_decode
  import portctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStb_t           stb
);
  always_comb begin
    stb = '{ctrlSet: 1'b0, ctrlClr: 1'b0, ieSet: 1'b0, ieClr: 1'b0,
            pendClr: 1'b0, rdSel: RD_NONE};
    case (addr)
      OFS_CTRL_SET: begin stb.ctrlSet = wrEn; stb.rdSel = RD_STATUS; end
      OFS_CTRL_CLR: begin stb.ctrlClr = wrEn; stb.rdSel = RD_CTRL;   end
      OFS_PEND:     begin stb.pendClr = wrEn; stb.rdSel = RD_PEND;   end
      OFS_IE_SET:   begin stb.ieSet   = wrEn; stb.rdSel = RD_IE;     end
      OFS_IE_CLR:   begin stb.ieClr   = wrEn; stb.rdSel = RD_IE;     end
      default: ;
    endcase
  end

  // One register action per write, none without a write (R9)
  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ctrlSet, stb.ctrlClr, stb.ieSet, stb.ieClr, stb.pendClr}));
  assert_no_write_no_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(stb.ctrlSet | stb.ctrlClr | stb.ieSet | stb.ieClr | stb.pendClr));
endmodule

// File: rtl/port_ctrl_datapath.sv
module port_ctrl_datapath
  import portctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStb_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              linkReady,
  input  logic              cmdDone,
  input  logic              cmdErr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ctrlWord,
  output logic              irq
);
  logic [DATA_W-1:0] ctrlQ, ieQ, pendQ, evNow, statusWord;
  logic              portReadyQ, readyNext;

  assign readyNext = linkReady & ~ctrlQ[BIT_RESET];

  always_comb begin
    evNow = '0;
    evNow[EV_DONE]  = cmdDone;
    evNow[EV_ERR]   = cmdErr;
    evNow[EV_READY] = readyNext ^ portReadyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ      <= CTRL_INIT;
      ieQ        <= '0;
      pendQ      <= '0;
      portReadyQ <= 1'b0;
    end else begin
      if (stb.ctrlSet) ctrlQ <= (ctrlQ | wrData) & CTRL_MASK;
      else if (stb.ctrlClr) ctrlQ <= ctrlQ & ~wrData & CTRL_MASK;
      if (stb.ieSet) ieQ <= (ieQ | wrData) & EV_MASK;
      else if (stb.ieClr) ieQ <= ieQ & ~wrData & EV_MASK;
      pendQ      <= ((stb.pendClr ? (pendQ & ~wrData) : pendQ) | evNow) & EV_MASK;
      portReadyQ <= readyNext;
    end
  end

  always_comb begin
    statusWord = ctrlQ;
    statusWord[BIT_READY] = portReadyQ;
  end

  always_comb begin
    case (stb.rdSel)
      RD_STATUS: rdData = statusWord;
      RD_CTRL:   rdData = ctrlQ;
      RD_PEND:   rdData = pendQ;
      RD_IE:     rdData = ieQ;
      default:   rdData = '0;
    endcase
  end

  assign ctrlWord = ctrlQ;
  assign irq      = |(ieQ & pendQ);

  assert_set_takes_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.ctrlSet |=> ((ctrlQ & $past(wrData & CTRL_MASK)) == $past(wrData & CTRL_MASK)));
  assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.ctrlClr |=> ((ctrlQ & $past(wrData & CTRL_MASK)) == '0));
  assert_unimpl_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ & ~CTRL_MASK) == '0);
  assert_reset_drops_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlQ[BIT_RESET]) |=> !portReadyQ);
  assert_ie_clear_takes_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.ieClr |=> ((ieQ & $past(wrData & EV_MASK)) == '0));
  assert_ready_change_pends_R7: assert property (@(posedge clk) disable iff (!rstN)
    (portReadyQ != $past(portReadyQ)) |-> pendQ[EV_READY]);
  assert_quiet_when_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ieQ == '0) |-> !irq);
endmodule

// File: rtl/port_ctrl_regs.sv
module port_ctrl_regs
  import portctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              linkReady,
  input  logic              cmdDone,
  input  logic              cmdErr,
  output logic              portResetOut,
  output logic              act32Out,
  output logic              pmEnableOut,
  output logic              irq
);
  regStb_t           stb;
  logic [DATA_W-1:0] ctrlWord;

  port_ctrl_decode decode_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .stb(stb)
  );

  port_ctrl_datapath datapath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .linkReady(linkReady), .cmdDone(cmdDone), .cmdErr(cmdErr),
    .rdData(rdData), .ctrlWord(ctrlWord), .irq(irq)
  );

  assign portResetOut = ctrlWord[BIT_RESET];
  assign act32Out     = ctrlWord[BIT_ACT32];
  assign pmEnableOut  = ctrlWord[BIT_PMEN];
endmodule

// File: tb/port_ctrl_regs_tb.sv
module port_ctrl_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        linkReady = 1'b0, cmdDone = 1'b0, cmdErr = 1'b0;
  logic        portResetOut, act32Out, pmEnableOut, irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_ctrl_regs dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .linkReady(linkReady), .cmdDone(cmdDone), .cmdErr(cmdErr),
    .portResetOut(portResetOut), .act32Out(act32Out), .pmEnableOut(pmEnableOut),
    .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rdCheck(string req, logic [12:0] a, logic [31:0] exp);
    addr = a; #1;
    check(req, rdData, exp);
  endtask

  task automatic testReset();
    rdCheck("R1 status", 13'h1000, 32'h1);
    rdCheck("R1 ctrl", 13'h1004, 32'h1);
    rdCheck("R1 ie", 13'h1010, 32'h0);
    rdCheck("R1 pend", 13'h1008, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 portReset", {31'b0, portResetOut}, 32'h1);
  endtask

  task automatic testSetClear();
    wr(13'h1000, 32'h0000_2400);
    rdCheck("R2 set bits", 13'h1004, 32'h2401);
    wr(13'h1000, 32'h0);
    rdCheck("R2 zero no effect", 13'h1004, 32'h2401);
    wr(13'h1000, 32'hFFFF_FFFF);
    rdCheck("R4 unimpl zero", 13'h1004, 32'h2401);
    check("R4 outputs", {29'b0, pmEnableOut, act32Out, portResetOut}, 32'h7);
    wr(13'h1004, 32'h0000_0400);
    rdCheck("R3 clear act32", 13'h1004, 32'h2001);
    wr(13'h1004, 32'h0);
    rdCheck("R3 zero no effect", 13'h1004, 32'h2001);
    wr(13'h1004, 32'h0000_0001);
    rdCheck("R3 release reset", 13'h1004, 32'h2000);
    check("R4 portReset low", {31'b0, portResetOut}, 32'h0);
  endtask

  task automatic testReady();
    linkReady = 1'b1;
    @(negedge clk);
    rdCheck("R5 ready up", 13'h1000, 32'h8000_2000);
    rdCheck("R7 ready change pends", 13'h1008, 32'h4);
    check("R8 masked irq", {31'b0, irq}, 32'h0);
    wr(13'h1010, 32'h4);
    check("R8 irq on enable", {31'b0, irq}, 32'h1);
    wr(13'h1008, 32'h4);
    rdCheck("R7 w1c", 13'h1008, 32'h0);
    check("R8 irq after clear", {31'b0, irq}, 32'h0);
    wr(13'h1000, 32'h1);
    rdCheck("R5 one cycle lag", 13'h1000, 32'h8000_2001);
    @(negedge clk);
    rdCheck("R5 ready down", 13'h1000, 32'h0000_2001);
    check("R7 fall pends irq", {31'b0, irq}, 32'h1);
    wr(13'h1008, 32'h4);
  endtask

  task automatic testEnables();
    wr(13'h1010, 32'h7);
    rdCheck("R6 ie set", 13'h1010, 32'h7);
    wr(13'h1014, 32'h2);
    rdCheck("R6 ie clear", 13'h1014, 32'h5);
    wr(13'h1010, 32'hFFFF_FFF8);
    rdCheck("R6 high bits zero", 13'h1010, 32'h5);
  endtask

  task automatic testEvents();
    cmdDone = 1'b1; @(negedge clk); cmdDone = 1'b0;
    rdCheck("R7 done pends", 13'h1008, 32'h1);
    check("R8 done irq", {31'b0, irq}, 32'h1);
    cmdErr = 1'b1; @(negedge clk); cmdErr = 1'b0;
    rdCheck("R7 err pends", 13'h1008, 32'h3);
    wr(13'h1008, 32'h1);
    check("R8 err disabled", {31'b0, irq}, 32'h0);
    cmdDone = 1'b1;
    wr(13'h1008, 32'h3);
    cmdDone = 1'b0;
    rdCheck("R7 event beats clear", 13'h1008, 32'h1);
    check("R8 irq kept", {31'b0, irq}, 32'h1);
  endtask

  task automatic testUnmapped();
    wr(13'h100C, 32'hFFFF_FFFF);
    wr(13'h0000, 32'hFFFF_FFFF);
    rdCheck("R9 read zero", 13'h100C, 32'h0);
    rdCheck("R9 ctrl kept", 13'h1004, 32'h2001);
    rdCheck("R9 ie kept", 13'h1010, 32'h5);
    rdCheck("R9 pend kept", 13'h1008, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSetClear();
    testReady();
    testEnables();
    testEvents();
    testUnmapped();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule